// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register core of a general-purpose I/O controller with four banks of 32 pins. Each bank keeps a direction word, an output latch and two alternate-function words. Software changes the output latch through two write-only style registers: one sets the bits written as one, and the other clears them. Reading a bank's level register returns a composite word. On output pins it shows the latch. On input pins it shows the sampled pin value.

Access is through a simple synchronous register bus addressed by byte offset. Read data appears one cycle after the request. The block drives one output-enable and one output-value vector covering all pins. It also raises a one-cycle strobe on every level-register read, so a neighbour can react to software polling the pins. Edge detection, interrupts, pad drivers and alternate-function muxing are handled elsewhere.

Pin n lives in bank n>>5 at bit n&31. Banks 0 to 2 sit in a contiguous window. Bank 3 sits 0x100 above the bank 0 register of the same kind. Alternate-function words are the exception to this rule and are listed in R9.

Top module: `gpio_bank_file`

## Requirements
- R1: After reset every direction, latch, alternate-function and set-shadow word reads zero, and pin_oe and pin_out are all zero.
- R2: A write to a set register (0x018, 0x01C, 0x020, 0x118 for banks 0..3) ORs wdata into that bank's latch.
- R3: A write to a clear register (0x024, 0x028, 0x02C, 0x124) ANDs that bank's latch with ~wdata.
- R4: pin_oe equals the direction words (bit = 1 means output), and pin_out equals latch AND direction, so input pins drive 0.
- R5: A level read (0x000, 0x004, 0x008, 0x100) returns the latch on output pins and, on input pins, pin_in as registered at the previous clock edge.
- R6: A set-register read returns the last value written there. A clear-register read returns the constant parameter CLR_RD_VALUE.
- R7: Reads at offsets of 0x200 and above, and reads of unmapped offsets below it, return zero. Writes to those offsets change nothing.
- R8: Each accepted level read produces lvl_rd_pulse high for exactly the cycle after the request. No other read produces the pulse.
- R9: Each bank has a readable and writable low and high alternate-function word. The low words are at 0x054, 0x05C, 0x064 and 0x06C. The high words are at 0x058, 0x060, 0x068 and 0x070.
- R10: The direction registers are at 0x00C, 0x010, 0x014 and 0x10C. Bank b maps to pins 32b..32b+31 of pin_in, pin_oe and pin_out.
- R11: rdata is registered. It updates one cycle after rd_en and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pin_in | input | 4*DATA_W | Sampled pin input levels |
| pin_oe | output | 4*DATA_W | Per-pin output enable |
| pin_out | output | 4*DATA_W | Per-pin output value |
| lvl_rd_pulse | output | 1 | One-cycle strobe after a level-register read |

## Verification
The bench builds the block with its defaults: DATA_W = 32, ADDR_W = 12 and CLR_RD_VALUE = 32'h0BAD_C1EA. With a 12-bit offset, the bench can write to 0x20C, which aliases the bank 0 direction register if bit 9 is dropped from the decode. That exposes a decoder that wraps the window. The full 32-bit banks let mixed-direction patterns show the merge in the level read on both halves of a word. The known clear-read constant lets the bench check the clear-register read exactly.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_LEVEL,
    KIND_DIR,
    KIND_SET,
    KIND_CLR,
    KIND_AF_LO,
    KIND_AF_HI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [BANK_IDX_W-1:0] bank;
  } reg_sel_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int unsigned WIN_W = 9;

  logic            in_window;
  logic [WIN_W-1:0] off;

  assign in_window = (addr >> WIN_W) == '0;
  assign off       = addr[WIN_W-1:0];

  always_comb begin
    sel.kind = KIND_NONE;
    sel.bank = '0;
    if (in_window) begin
      case (off)
        9'h000: begin sel.kind = KIND_LEVEL; sel.bank = 2'd0; end
        9'h004: begin sel.kind = KIND_LEVEL; sel.bank = 2'd1; end
        9'h008: begin sel.kind = KIND_LEVEL; sel.bank = 2'd2; end
        9'h100: begin sel.kind = KIND_LEVEL; sel.bank = 2'd3; end
        9'h00C: begin sel.kind = KIND_DIR;   sel.bank = 2'd0; end
        9'h010: begin sel.kind = KIND_DIR;   sel.bank = 2'd1; end
        9'h014: begin sel.kind = KIND_DIR;   sel.bank = 2'd2; end
        9'h10C: begin sel.kind = KIND_DIR;   sel.bank = 2'd3; end
        9'h018: begin sel.kind = KIND_SET;   sel.bank = 2'd0; end
        9'h01C: begin sel.kind = KIND_SET;   sel.bank = 2'd1; end
        9'h020: begin sel.kind = KIND_SET;   sel.bank = 2'd2; end
        9'h118: begin sel.kind = KIND_SET;   sel.bank = 2'd3; end
        9'h024: begin sel.kind = KIND_CLR;   sel.bank = 2'd0; end
        9'h028: begin sel.kind = KIND_CLR;   sel.bank = 2'd1; end
        9'h02C: begin sel.kind = KIND_CLR;   sel.bank = 2'd2; end
        9'h124: begin sel.kind = KIND_CLR;   sel.bank = 2'd3; end
        9'h054: begin sel.kind = KIND_AF_LO; sel.bank = 2'd0; end
        9'h05C: begin sel.kind = KIND_AF_LO; sel.bank = 2'd1; end
        9'h064: begin sel.kind = KIND_AF_LO; sel.bank = 2'd2; end
        9'h06C: begin sel.kind = KIND_AF_LO; sel.bank = 2'd3; end
        9'h058: begin sel.kind = KIND_AF_HI; sel.bank = 2'd0; end
        9'h060: begin sel.kind = KIND_AF_HI; sel.bank = 2'd1; end
        9'h068: begin sel.kind = KIND_AF_HI; sel.bank = 2'd2; end
        9'h070: begin sel.kind = KIND_AF_HI; sel.bank = 2'd3; end
        default: begin sel.kind = KIND_NONE; sel.bank = '0; end
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  reg_kind_e         wr_kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_s,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] lat_q,
  output logic [DATA_W-1:0] af_lo_q,
  output logic [DATA_W-1:0] af_hi_q,
  output logic [DATA_W-1:0] set_sh_q,
  output logic [DATA_W-1:0] level
);

  logic [DATA_W-1:0] dir_d, lat_d, af_lo_d, af_hi_d, set_sh_d;
  logic              dir_en, lat_en, af_lo_en, af_hi_en, set_sh_en;

  // Next-state and clock enables
  always_comb begin
    dir_en    = wr_hit && (wr_kind == KIND_DIR);
    af_lo_en  = wr_hit && (wr_kind == KIND_AF_LO);
    af_hi_en  = wr_hit && (wr_kind == KIND_AF_HI);
    set_sh_en = wr_hit && (wr_kind == KIND_SET);
    lat_en    = wr_hit && ((wr_kind == KIND_SET) || (wr_kind == KIND_CLR));
    dir_d     = wdata;
    af_lo_d   = wdata;
    af_hi_d   = wdata;
    set_sh_d  = wdata;
    if (wr_kind == KIND_SET) lat_d = lat_q | wdata;
    else                     lat_d = lat_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      lat_q    <= '0;
      af_lo_q  <= '0;
      af_hi_q  <= '0;
      set_sh_q <= '0;
    end else begin
      if (dir_en)    dir_q    <= dir_d;
      if (lat_en)    lat_q    <= lat_d;
      if (af_lo_en)  af_lo_q  <= af_lo_d;
      if (af_hi_en)  af_hi_q  <= af_hi_d;
      if (set_sh_en) set_sh_q <= set_sh_d;
    end
  end

  assign level = (lat_q & dir_q) | (pin_s & ~dir_q);

endmodule

// File: rtl/gpio_bank_file.sv
module gpio_bank_file
  import gpio_regs_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       ADDR_W       = 12,
  parameter logic [DATA_W-1:0] CLR_RD_VALUE = 32'h0BAD_C1EA
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic [NUM_BANKS*DATA_W-1:0]   pin_in,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_oe,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_out,
  output logic                          lvl_rd_pulse
);

  localparam int unsigned PINS = NUM_BANKS * DATA_W;

  logic              rst_n_s;
  reg_sel_t          sel;
  logic [PINS-1:0]   pin_s_q;
  logic [DATA_W-1:0] dir_w    [NUM_BANKS];
  logic [DATA_W-1:0] lat_w    [NUM_BANKS];
  logic [DATA_W-1:0] af_lo_w  [NUM_BANKS];
  logic [DATA_W-1:0] af_hi_w  [NUM_BANKS];
  logic [DATA_W-1:0] set_sh_w [NUM_BANKS];
  logic [DATA_W-1:0] level_w  [NUM_BANKS];
  logic [DATA_W-1:0] rdata_d;
  logic              pulse_d;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_s)
  );

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr),
    .sel (sel)
  );

  // Input sampling register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pin_s_q <= '0;
    else          pin_s_q <= pin_in;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en && (sel.kind != KIND_NONE) && (sel.bank == BANK_IDX_W'(b));

    gpio_bank_regs #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_hit  (bank_wr),
      .wr_kind (sel.kind),
      .wdata   (wdata),
      .pin_s   (pin_s_q[b*DATA_W +: DATA_W]),
      .dir_q   (dir_w[b]),
      .lat_q   (lat_w[b]),
      .af_lo_q (af_lo_w[b]),
      .af_hi_q (af_hi_w[b]),
      .set_sh_q(set_sh_w[b]),
      .level   (level_w[b])
    );

    assign pin_oe [b*DATA_W +: DATA_W] = dir_w[b];
    assign pin_out[b*DATA_W +: DATA_W] = lat_w[b] & dir_w[b];
  end

  // Read-data selection
  always_comb begin
    case (sel.kind)
      KIND_LEVEL: rdata_d = level_w[sel.bank];
      KIND_DIR:   rdata_d = dir_w[sel.bank];
      KIND_SET:   rdata_d = set_sh_w[sel.bank];
      KIND_CLR:   rdata_d = CLR_RD_VALUE;
      KIND_AF_LO: rdata_d = af_lo_w[sel.bank];
      KIND_AF_HI: rdata_d = af_hi_w[sel.bank];
      default:    rdata_d = '0;
    endcase
    pulse_d = rd_en && (sel.kind == KIND_LEVEL);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata        <= '0;
      lvl_rd_pulse <= 1'b0;
    end else begin
      if (rd_en) rdata <= rdata_d;
      lvl_rd_pulse <= pulse_d;
    end
  end

endmodule

// File: rtl/gpio_bank_file_chk.sv
module gpio_bank_file_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   pin_out,
  input logic              lvl_rd_pulse
);

  // R4: an input pin never drives a one
  p_no_drive_on_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R2: bank 0 set write leaves every written output bit high
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h018)) |=>
      ((pin_out[DATA_W-1:0] & $past(wdata)) == (pin_oe[DATA_W-1:0] & $past(wdata))));

  // R3: bank 0 clear write leaves every written output bit low
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h024)) |=> ((pin_out[DATA_W-1:0] & $past(wdata)) == '0));

  // R7: writes above the window change no pin
  p_high_write_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'('h200)) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R7, R8: reads above the window give zero and no strobe
  p_high_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'('h200)) |=> (rdata == '0 && !lvl_rd_pulse));

  // R8: strobe follows a read request
  p_pulse_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !lvl_rd_pulse);

  // R11: read data holds without a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_bank_file gpio_bank_file_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .PINS  (PINS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .pin_oe      (pin_oe),
  .pin_out     (pin_out),
  .lvl_rd_pulse(lvl_rd_pulse)
);

// File: tb/tb_gpio_bank_file.sv
module tb_gpio_bank_file;

  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [31:0] CLR_C = 32'h0BAD_C1EA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [127:0]  pin_in = '0;
  logic [127:0]  pin_oe, pin_out;
  logic          lvl_rd_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_file dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .lvl_rd_pulse(lvl_rd_pulse)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // pin_in during the table: bank3 33333333, bank2 22222222, bank1 11110000, bank0 F0F0F0F0
  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h00C, 32'h0, 32'h0000_0000, 4'd1},   // R1 dir reset
    '{1'b0, 12'h000, 32'h0, 32'hF0F0_F0F0, 4'd5},   // R5 all inputs
    '{1'b0, 12'h004, 32'h0, 32'h1111_0000, 4'd10},  // R10 bank 1 lanes
    '{1'b0, 12'h100, 32'h0, 32'h3333_3333, 4'd10},  // R10 bank 3 window
    '{1'b1, 12'h00C, 32'hFFFF_0000, 32'h0, 4'd4},
    '{1'b1, 12'h018, 32'h1234_5678, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 32'h1234_F0F0, 4'd2},   // R2/R5 merge
    '{1'b0, 12'h018, 32'h0, 32'h1234_5678, 4'd6},   // R6 set shadow
    '{1'b0, 12'h024, 32'h0, CLR_C,         4'd6},   // R6 clear constant
    '{1'b1, 12'h024, 32'h0000_FF00, 32'h0, 4'd3},
    '{1'b1, 12'h018, 32'h0001_0000, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 32'h1235_F0F0, 4'd3},   // R3 then R2
    '{1'b1, 12'h10C, 32'hFFFF_FFFF, 32'h0, 4'd10},
    '{1'b1, 12'h118, 32'hCAFE_BABE, 32'h0, 4'd10},
    '{1'b0, 12'h100, 32'h0, 32'hCAFE_BABE, 4'd10},
    '{1'b0, 12'h008, 32'h0, 32'h2222_2222, 4'd10},
    '{1'b1, 12'h054, 32'h1111_2222, 32'h0, 4'd9},
    '{1'b1, 12'h058, 32'h3333_4444, 32'h0, 4'd9},
    '{1'b1, 12'h070, 32'h5555_6666, 32'h0, 4'd9},
    '{1'b0, 12'h054, 32'h0, 32'h1111_2222, 4'd9},   // R9
    '{1'b0, 12'h058, 32'h0, 32'h3333_4444, 4'd9},
    '{1'b0, 12'h070, 32'h0, 32'h5555_6666, 4'd9},
    '{1'b0, 12'h06C, 32'h0, 32'h0000_0000, 4'd9},
    '{1'b1, 12'h200, 32'hFFFF_FFFF, 32'h0, 4'd7},
    '{1'b1, 12'h20C, 32'hFFFF_FFFF, 32'h0, 4'd7},
    '{1'b0, 12'h200, 32'h0, 32'h0000_0000, 4'd7},   // R7
    '{1'b0, 12'h030, 32'h0, 32'h0000_0000, 4'd7},
    '{1'b0, 12'h00C, 32'h0, 32'hFFFF_0000, 4'd7},
    '{1'b0, 12'h10C, 32'h0, 32'hFFFF_FFFF, 4'd7}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic p);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    #2;
    d = rdata;
    p = lvl_rd_pulse;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] rd;
    logic pl;
    pin_in = {32'h3333_3333, 32'h2222_2222, 32'h1111_0000, 32'hF0F0_F0F0};
    do_reset();
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].a, VECS[i].d);
      else begin
        bus_read(VECS[i].a, rd, pl);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // R4 and R10: pin vectors per bank
    check("R4 oe bank0", pin_oe[31:0], 32'hFFFF_0000);
    check("R4 out bank0", pin_out[31:0], 32'h1235_0000);
    check("R10 oe bank1", pin_oe[63:32], 32'h0);
    check("R10 out bank3", pin_out[127:96], 32'hCAFE_BABE);

    // R8: pulse after level read only, lasting one cycle
    bus_read(12'h008, rd, pl);
    check("R8 pulse on level read", pl, 1'b1);
    @(posedge clk); #2;
    check("R8 pulse one cycle", lvl_rd_pulse, 1'b0);
    bus_read(12'h00C, rd, pl);
    check("R8 no pulse on dir read", pl, 1'b0);

    // R11: rdata holds with no read
    repeat (3) @(negedge clk);
    check("R11 rdata hold", rdata, 32'hFFFF_0000);

    // R5: bank 0 back to input, new pin pattern
    bus_write(12'h00C, 32'h0);
    pin_in[31:0] = 32'h0F0F_1234;
    repeat (2) @(negedge clk);
    bus_read(12'h000, rd, pl);
    check("R5 input level", rd, 32'h0F0F_1234);
    check("R4 input drives zero", pin_out[31:0], 32'h0);

    // R1: reset mid-run clears everything
    do_reset();
    check("R1 oe after reset", pin_oe, '0);
    check("R1 out after reset", pin_out, '0);
    bus_read(12'h10C, rd, pl);
    check("R1 dir bank3", rd, 32'h0);
    bus_read(12'h118, rd, pl);
    check("R1 set shadow", rd, 32'h0);
    bus_read(12'h058, rd, pl);
    check("R1 af high", rd, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule